// File: doc/BRIEF.md
# Shared-Timer Underload Detector

This block watches one underload comparator flag per half-bridge channel and decides when an open-load style fault has lasted long enough to report. Only channels whose driver is commanded on and not already latched off take part. Instead of one delay counter per channel, a single shared counter measures how long *some* channel has been in underload without a break. A channel that joins a running underload gets only the time left on that counter, not a fresh delay.

When the shared counter reaches its limit, the block sets a sticky status bit. If the shutdown-enable input is high at that moment, it also latches off every channel that is in underload then. A status-reset command (`clr_i`) clears the status bit and all latch-offs and restarts the counter. The delay is a parameter in clock cycles, with a default of 350. Current sensing is done outside the block.

Top module: `uld_detect_top`

## Requirements
- R1: After synchronous reset, `uld_stat_o` is 0 and every bit of `latch_off_o` is 0.
- R2: A channel takes part only while its `drv_on_i` bit is 1. An underload flag on a channel that is off never advances the timer and never sets status, however long it lasts.
- R3: With DELAY_CYC = D, `uld_stat_o` rises on the clock edge after the underload has been sampled active on D+1 consecutive edges. After D such edges it is still 0.
- R4: One edge on which no participating channel is in underload resets the timer to zero. The next underload needs the full D+1 edges again.
- R5: While at least one participating channel stays in underload, the timer keeps counting. A channel whose underload begins later inherits the running count, even if the first channel recovers.
- R6: At expiry, a channel is latched off (its `latch_off_o` bit, bit i for channel i, goes to 1) only if `shdn_en_i` is 1 and that channel is in underload. With `shdn_en_i` = 0 the status still sets and no channel latches.
- R7: While the timer stays expired, a channel that enters underload with `shdn_en_i` = 1 is latched off on the next edge, without a new delay.
- R8: A channel that is latched off no longer counts as in underload, so it cannot keep the timer running.
- R9: `clr_i` high at an edge clears `uld_stat_o` and all of `latch_off_o` and restarts the timer. If the underload persists, the status sets again after a full D+1 edges.
- R10: When `clr_i` coincides with the edge on which the timer would expire, the clear wins and status stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uld_flag_i | input | NUM_CH | Per-channel underload comparator flag, bit i = channel i |
| drv_on_i | input | NUM_CH | Per-channel driver-on mask (either side of the bridge on) |
| shdn_en_i | input | 1 | Latch off underloaded channels at expiry |
| clr_i | input | 1 | Status-reset command strobe |
| uld_stat_o | output | 1 | Sticky underload status |
| latch_off_o | output | NUM_CH | Per-channel latch-off, bit i = channel i |

## Verification
The hardest situation to reach from the ports is an inherited window. A second channel must be flagged for only a few edges, yet be latched because a first channel, now recovered, had already used up most of the delay. The stimulus staggers two flags so that their union is unbroken while neither alone spans the delay.

Two other cases need the same care. The clear must land exactly on the expiry edge. The immediate latch after expiry is reached by expiring with shutdown disabled, then enabling shutdown in the same cycle a new channel raises its flag.

// File: rtl/uld_pkg.sv
package uld_pkg;
  // width needed to hold a count from 0 up to and including lim
  function automatic int cnt_width(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/uld_qualify.sv
module uld_qualify #(
  parameter int NUM_CH = 3
) (
  input  logic [NUM_CH-1:0] flag_i,
  input  logic [NUM_CH-1:0] on_i,
  input  logic [NUM_CH-1:0] latched_i,
  output logic [NUM_CH-1:0] act_o,
  output logic              any_act_o
);
  // a channel counts only while driven and not already latched off (R2, R8)
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign act_o[g] = flag_i[g] & on_i[g] & ~latched_i[g];
  end
  assign any_act_o = |act_o;
endmodule

// File: rtl/uld_shared_timer.sv
module uld_shared_timer #(
  parameter int DELAY_CYC = 350
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic any_act_i,
  output logic elapsed_o
);
  localparam int CW = uld_pkg::cnt_width(DELAY_CYC);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i)  cnt_q <= '0;
    else if (!any_act_i)   cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign elapsed_o = (cnt_q == LIMIT);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);

  p_idle_restart_r4: assert property (@(posedge clk) disable iff (rst)
    !any_act_i |=> cnt_q == '0);

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (any_act_i && !restart_i && cnt_q != LIMIT) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/uld_latch_bank.sv
module uld_latch_bank #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              elapsed_i,
  input  logic              shdn_en_i,
  input  logic [NUM_CH-1:0] act_i,
  output logic              stat_o,
  output logic [NUM_CH-1:0] latch_o
);
  logic              stat_q;
  logic [NUM_CH-1:0] latch_q;
  logic              fire;

  assign fire = elapsed_i & (|act_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i) stat_q <= 1'b0;
    else if (fire)    stat_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst || clr_i) latch_q[g] <= 1'b0;
      else if (elapsed_i && act_i[g] && shdn_en_i) latch_q[g] <= 1'b1;
    end

    p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (latch_q[g] && !clr_i) |=> latch_q[g]);
  end

  assign stat_o  = stat_q;
  assign latch_o = latch_q;

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!stat_q && latch_q == '0));

  p_latch_implies_stat_r6: assert property (@(posedge clk) disable iff (rst)
    (latch_q != '0) |-> stat_q);
endmodule

// File: rtl/uld_detect_top.sv
module uld_detect_top #(
  parameter int NUM_CH    = 3,
  parameter int DELAY_CYC = 350
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] uld_flag_i,
  input  logic [NUM_CH-1:0] drv_on_i,
  input  logic              shdn_en_i,
  input  logic              clr_i,
  output logic              uld_stat_o,
  output logic [NUM_CH-1:0] latch_off_o
);
  logic [NUM_CH-1:0] act;
  logic              any_act;
  logic              elapsed;

  uld_qualify #(.NUM_CH(NUM_CH)) qual_i (
    .flag_i(uld_flag_i), .on_i(drv_on_i), .latched_i(latch_off_o),
    .act_o(act), .any_act_o(any_act));

  uld_shared_timer #(.DELAY_CYC(DELAY_CYC)) tmr_i (
    .clk(clk), .rst(rst), .restart_i(clr_i),
    .any_act_i(any_act), .elapsed_o(elapsed));

  uld_latch_bank #(.NUM_CH(NUM_CH)) bank_i (
    .clk(clk), .rst(rst), .clr_i(clr_i), .elapsed_i(elapsed),
    .shdn_en_i(shdn_en_i), .act_i(act),
    .stat_o(uld_stat_o), .latch_o(latch_off_o));

  p_stat_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(uld_stat_o) |-> $past(|(uld_flag_i & drv_on_i) && !clr_i));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_latch_cause_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(latch_off_o[g]) |-> $past(shdn_en_i && drv_on_i[g] && uld_flag_i[g]));
  end
endmodule

// File: tb/uld_detect_top_tb_top.sv
module uld_detect_top_tb_top;
  localparam int NCH = 3;
  localparam int D   = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] flag = '0;
  logic [NCH-1:0] on   = '1;
  logic           shdn = 1'b0;
  logic           clr  = 1'b0;
  logic           stat;
  logic [NCH-1:0] loff;
  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  uld_detect_top #(.NUM_CH(NCH), .DELAY_CYC(D)) dut_i (
    .clk(clk), .rst(rst), .uld_flag_i(flag), .drv_on_i(on),
    .shdn_en_i(shdn), .clr_i(clr), .uld_stat_o(stat), .latch_off_o(loff));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cleanup();
    flag = '0; on = '1; shdn = 1'b0;
    clr = 1'b1; tick(1); clr = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    chk("R1 status", {7'b0, stat}, 8'h0);
    chk("R1 latch",  {5'b0, loff}, 8'h0);
  endtask

  task automatic t_off_ignored();
    cleanup();
    on = 3'b110; flag = 3'b001; tick(3*D);
    chk("R2 off channel ignored", {7'b0, stat}, 8'h0);
    on = 3'b111; tick(D);
    chk("R2 fresh window after on", {7'b0, stat}, 8'h0);
    tick(1);
    chk("R2 sets after on", {7'b0, stat}, 8'h1);
  endtask

  task automatic t_basic_no_shdn();
    cleanup();
    flag = 3'b100; tick(D);
    chk("R3 not yet at D", {7'b0, stat}, 8'h0);
    tick(1);
    chk("R3 set at D+1", {7'b0, stat}, 8'h1);
    chk("R6 no latch when disabled", {5'b0, loff}, 8'h0);
  endtask

  task automatic t_gap();
    cleanup();
    flag = 3'b001; tick(D);
    flag = 3'b000; tick(1);
    flag = 3'b001; tick(D);
    chk("R4 gap restarts timer", {7'b0, stat}, 8'h0);
    tick(1);
    chk("R4 set after fresh window", {7'b0, stat}, 8'h1);
  endtask

  task automatic t_clear();
    // continues with ch0 still in underload and status set
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R9 status cleared", {7'b0, stat}, 8'h0);
    chk("R9 latch cleared",  {5'b0, loff}, 8'h0);
    tick(D);
    chk("R9 timer restarted", {7'b0, stat}, 8'h0);
    tick(1);
    chk("R9 relatched", {7'b0, stat}, 8'h1);
  endtask

  task automatic t_clear_wins();
    cleanup();
    flag = 3'b010; tick(D);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R10 clear beats expiry", {7'b0, stat}, 8'h0);
    tick(D);
    chk("R10 restarted window", {7'b0, stat}, 8'h0);
    tick(1);
    chk("R10 sets afterwards", {7'b0, stat}, 8'h1);
  endtask

  task automatic t_inherit();
    cleanup();
    shdn = 1'b1;
    flag = 3'b001; tick(4);
    flag = 3'b011; tick(3);
    flag = 3'b010; tick(3);
    chk("R5 not expired yet", {7'b0, stat}, 8'h0);
    tick(1);
    chk("R5 inherited expiry", {7'b0, stat}, 8'h1);
    chk("R6 only ch1 latched", {5'b0, loff}, 8'h2);
    // ch1 latched, flag still high: must not keep timer alive
    tick(1);
    flag = 3'b011; tick(D);
    chk("R8 latched channel ignored", {5'b0, loff}, 8'h2);
    tick(1);
    chk("R8 ch0 latched after full delay", {5'b0, loff}, 8'h3);
  endtask

  task automatic t_after_expiry();
    cleanup();
    flag = 3'b001; tick(D+1);
    chk("R6 status without latch", {4'b0, stat, loff}, 8'h8);
    flag = 3'b101; shdn = 1'b1; tick(1);
    chk("R7 immediate latch", {5'b0, loff}, 8'h5);
  endtask

  initial begin
    fork
      begin
        tick(3); rst = 1'b0; tick(1);
        t_reset();
        t_off_ignored();
        t_basic_no_shdn();
        t_gap();
        t_clear();
        t_clear_wins();
        t_inherit();
        t_after_expiry();
      end
      begin
        #(20 * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule